// File: doc/BRIEF.md
# SCSI Bus DMA Handshake Sequencer

This block carries bytes between a host-side DMA request/acknowledge pair and the REQ/ACK handshake of a parallel SCSI bus. It handles three transfer directions. In initiator send, host bytes go out on the bus. In target receive, the block acts as target and takes bytes from the initiator. In initiator receive, it takes bytes from a target. A write strobe to one of three consecutive register addresses starts a transfer, and the written value plays no part. The block raises a host request for each byte, or holds it for the whole transfer in block mode. It runs one bus handshake per byte and latches incoming bus data on the falling edge of the peer's strobe.

A transfer finishes once the host marks its last byte with the end-of-process input. The block also stops if, while it acts as initiator, the phase lines on the bus do not match the programmed phase when REQ arrives. Sticky flags report the end of DMA, the completion of the final send byte and a phase mismatch. An interrupt output combines these flags and is gated by an enable. The register file, arbitration and selection live elsewhere and supply the mode and phase inputs.

Top module: `scsi_dma_engine`

## Requirements
- R1: After reset, drq, ack_out, req_out, bus_doe, dma_end, last_sent, phase_err and irq are all 0.
- R2: A write strobe to address 5 starts an initiator send, to address 6 a target receive and to address 7 an initiator receive. A strobe to any other address starts nothing, so drq, req_out and bus_doe stay 0 even in block mode. A strobe that arrives during a transfer is ignored.
- R3: With block_mode at 0, drq is 1 only while a byte waits for the host, and it drops in the cycle after the clock edge at which dack is sampled high.
- R4: With block_mode at 1, drq is 1 from the cycle after the start strobe until the transfer ends, including during bus handshakes.
- R5: In initiator send, each byte taken with dack is driven on bus_dout with bus_doe at 1 while ACK is asserted. ack_out rises only after req_in has been seen high, stays high while req_in is high, and is released once req_in falls. Bytes appear on the bus in the order of the dack strobes.
- R6: In initiator receive, ack_out answers a high req_in. host_rdata takes the value that bus_din has in the cycle where req_in is first seen low, and ack_out is released at the same edge.
- R7: In target receive, req_out is asserted until ack_in is seen high. host_rdata takes the value that bus_din has in the cycle where ack_in is first seen low.
- R8: When host_eop is high together with dack, that byte is the last one. In send, the transfer ends when that byte's bus handshake completes. In receive, it ends at that dack. dma_end rises at the same edge at which drq falls, and it stays 0 before that.
- R9: last_sent is set only at the end of a send transfer, never at the end of a receive.
- R10: In an initiator direction, if bus_phase differs from phase_prog (bits MSG, CD, IO) when req_in is seen high, the transfer stops with ack_out never asserted. phase_err and irq are then set, and dma_end stays 0.
- R11: Ending a transfer by end-of-process sets irq only when eop_irq_en is 1.
- R12: An accepted start strobe clears dma_end, last_sent, phase_err and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| block_mode | input | 1 | 1: hold drq for the whole transfer |
| eop_irq_en | input | 1 | Enables the interrupt on end-of-process |
| phase_prog | input | 3 | Expected phase {MSG, CD, IO} |
| bus_phase | input | 3 | Phase lines seen on the bus {MSG, CD, IO} |
| drq | output | 1 | DMA request to the host |
| dack | input | 1 | DMA acknowledge from the host |
| host_eop | input | 1 | End-of-process, valid with dack |
| host_wdata | input | 8 | Byte from the host, valid with dack (send) |
| host_rdata | output | 8 | Byte latched from the bus (receive) |
| req_in | input | 1 | REQ line from the target |
| ack_in | input | 1 | ACK line from the initiator |
| req_out | output | 1 | REQ driven in target receive |
| ack_out | output | 1 | ACK driven in initiator directions |
| bus_din | input | 8 | Data lines seen on the bus |
| bus_dout | output | 8 | Data to drive on the bus |
| bus_doe | output | 1 | Enables the bus data drivers |
| dma_end | output | 1 | Transfer ended by end-of-process |
| last_sent | output | 1 | Final send byte has completed on the bus |
| phase_err | output | 1 | Transfer stopped on a phase mismatch |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach from the ports is showing that a receive byte is taken at the falling edge of the peer's strobe and not in the cycle before or after it. The bench's bus model therefore drives a decoy value while the strobe is high. It puts the real byte on the lines only in the same cycle in which it drops the strobe, and replaces it with a second decoy one cycle later. Any capture one cycle early or late then returns the wrong byte. Random byte counts, data, phases and wait lengths run in both DRQ modes. Directed runs cover the phase mismatch, the gated interrupt and strobes to non-start addresses.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

  typedef enum logic [1:0] {
    DIR_SEND  = 2'd0,
    DIR_TRECV = 2'd1,
    DIR_IRECV = 2'd2
  } xfer_dir_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOST = 3'd1,
    ST_IREQ = 3'd2,
    ST_IACK = 3'd3,
    ST_TREQ = 3'd4,
    ST_TREL = 3'd5
  } seq_state_e;

endpackage

// File: rtl/sdma_start_dec.sv
module sdma_start_dec
  import scsi_dma_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int A_BASE = 5
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              start,
  output xfer_dir_e         dir
);

  localparam int NUM_START = 3;

  logic [NUM_START-1:0] hit;

  // one decoder per start address; the address offset selects the direction
  for (genvar k = 0; k < NUM_START; k++) begin : g_hit
    assign hit[k] = wr && (addr == ADDR_W'(A_BASE + k));
  end

  always_comb begin
    start = |hit;
    if (hit[2])      dir = DIR_IRECV;
    else if (hit[1]) dir = DIR_TRECV;
    else             dir = DIR_SEND;
  end

endmodule

// File: rtl/sdma_fall_det.sv
module sdma_fall_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  xfer_dir_e          start_dir,
  input  logic               block_mode,
  input  logic [PHASE_W-1:0] phase_prog,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic               dack,
  input  logic               host_eop,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               req_in,
  input  logic               ack_in,
  input  logic               req_fall,
  input  logic               ack_fall,
  input  logic [DATA_W-1:0]  bus_din,
  output logic               drq,
  output logic               req_out,
  output logic               ack_out,
  output logic               bus_doe,
  output logic [DATA_W-1:0]  bus_dout,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               launch,
  output logic               finish,
  output logic               finish_send,
  output logic               mismatch
);

  seq_state_e        state_q, state_d;
  xfer_dir_e         dir_q, dir_d;
  logic              eop_q, eop_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic [DATA_W-1:0] din_q, din_d;
  logic              upd_dout, upd_din;

  // next-state process
  always_comb begin
    state_d     = state_q;
    dir_d       = dir_q;
    eop_d       = eop_q;
    dout_d      = dout_q;
    din_d       = din_q;
    upd_dout    = 1'b0;
    upd_din     = 1'b0;
    launch      = 1'b0;
    finish      = 1'b0;
    finish_send = 1'b0;
    mismatch    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          launch = 1'b1;
          dir_d  = start_dir;
          eop_d  = 1'b0;
          unique case (start_dir)
            DIR_SEND:  state_d = ST_HOST;
            DIR_TRECV: state_d = ST_TREQ;
            default:   state_d = ST_IREQ;
          endcase
        end
      end
      ST_HOST: begin
        if (dack) begin
          if (dir_q == DIR_SEND) begin
            upd_dout = 1'b1;
            dout_d   = host_wdata;
            eop_d    = host_eop;
            state_d  = ST_IREQ;
          end else if (host_eop) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = (dir_q == DIR_TRECV) ? ST_TREQ : ST_IREQ;
          end
        end
      end
      ST_IREQ: begin
        if (req_in) begin
          if (bus_phase != phase_prog) begin
            mismatch = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d = ST_IACK;
          end
        end
      end
      ST_IACK: begin
        if (req_fall) begin
          if (dir_q == DIR_SEND) begin
            if (eop_q) begin
              finish      = 1'b1;
              finish_send = 1'b1;
              state_d     = ST_IDLE;
            end else begin
              state_d = ST_HOST;
            end
          end else begin
            upd_din = 1'b1;
            din_d   = bus_din;
            state_d = ST_HOST;
          end
        end
      end
      ST_TREQ: begin
        if (ack_in) state_d = ST_TREL;
      end
      ST_TREL: begin
        if (ack_fall) begin
          upd_din = 1'b1;
          din_d   = bus_din;
          state_d = ST_HOST;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_SEND;
      eop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      eop_q   <= eop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_q <= '0;
    else if (upd_dout) dout_q <= dout_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       din_q <= '0;
    else if (upd_din) din_q <= din_d;
  end

  assign drq        = block_mode ? (state_q != ST_IDLE) : (state_q == ST_HOST);
  assign ack_out    = (state_q == ST_IACK);
  assign req_out    = (state_q == ST_TREQ);
  assign bus_doe    = (dir_q == DIR_SEND) && ((state_q == ST_IREQ) || (state_q == ST_IACK));
  assign bus_dout   = dout_q;
  assign host_rdata = din_q;

endmodule

// File: rtl/sdma_status.sv
module sdma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic finish,
  input  logic finish_send,
  input  logic mismatch,
  input  logic eop_irq_en,
  output logic dma_end,
  output logic last_sent,
  output logic phase_err,
  output logic irq
);

  logic end_q, end_d, last_q, last_d, perr_q, perr_d, irq_q, irq_d;

  always_comb begin
    end_d  = end_q;
    last_d = last_q;
    perr_d = perr_q;
    irq_d  = irq_q;
    if (launch) begin
      end_d  = 1'b0;
      last_d = 1'b0;
      perr_d = 1'b0;
      irq_d  = 1'b0;
    end else begin
      if (finish)                end_d  = 1'b1;
      if (finish_send)           last_d = 1'b1;
      if (finish && eop_irq_en)  irq_d  = 1'b1;
      if (mismatch) begin
        perr_d = 1'b1;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q  <= 1'b0;
      last_q <= 1'b0;
      perr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      end_q  <= end_d;
      last_q <= last_d;
      perr_q <= perr_d;
      irq_q  <= irq_d;
    end
  end

  assign dma_end   = end_q;
  assign last_sent = last_q;
  assign phase_err = perr_q;
  assign irq       = irq_q;

endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int PHASE_W = 3,
  parameter int A_BASE  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               block_mode,
  input  logic               eop_irq_en,
  input  logic [PHASE_W-1:0] phase_prog,
  input  logic [PHASE_W-1:0] bus_phase,
  output logic               drq,
  input  logic               dack,
  input  logic               host_eop,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               req_in,
  input  logic               ack_in,
  output logic               req_out,
  output logic               ack_out,
  input  logic [DATA_W-1:0]  bus_din,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  output logic               dma_end,
  output logic               last_sent,
  output logic               phase_err,
  output logic               irq
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  logic      start;
  xfer_dir_e start_dir;
  logic [1:0] strobe_fall;
  logic      launch, finish, finish_send, mismatch;

  sdma_start_dec #(
    .ADDR_W (ADDR_W),
    .A_BASE (A_BASE)
  ) u_dec (
    .wr    (reg_wr),
    .addr  (reg_addr),
    .start (start),
    .dir   (start_dir)
  );

  sdma_fall_det #(
    .W (2)
  ) u_fall (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sig   ({ack_in, req_in}),
    .fall  (strobe_fall)
  );

  sdma_seq #(
    .DATA_W  (DATA_W),
    .PHASE_W (PHASE_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .start_dir   (start_dir),
    .block_mode  (block_mode),
    .phase_prog  (phase_prog),
    .bus_phase   (bus_phase),
    .dack        (dack),
    .host_eop    (host_eop),
    .host_wdata  (host_wdata),
    .req_in      (req_in),
    .ack_in      (ack_in),
    .req_fall    (strobe_fall[0]),
    .ack_fall    (strobe_fall[1]),
    .bus_din     (bus_din),
    .drq         (drq),
    .req_out     (req_out),
    .ack_out     (ack_out),
    .bus_doe     (bus_doe),
    .bus_dout    (bus_dout),
    .host_rdata  (host_rdata),
    .launch      (launch),
    .finish      (finish),
    .finish_send (finish_send),
    .mismatch    (mismatch)
  );

  sdma_status u_stat (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .launch      (launch),
    .finish      (finish),
    .finish_send (finish_send),
    .mismatch    (mismatch),
    .eop_irq_en  (eop_irq_en),
    .dma_end     (dma_end),
    .last_sent   (last_sent),
    .phase_err   (phase_err),
    .irq         (irq)
  );

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker (
  input logic clk,
  input logic rst_n,
  input logic block_mode,
  input logic eop_irq_en,
  input logic drq,
  input logic dack,
  input logic req_in,
  input logic ack_in,
  input logic req_out,
  input logic ack_out,
  input logic dma_end,
  input logic last_sent,
  input logic phase_err,
  input logic irq
);

  AST_DRQ_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_end) |-> !drq);  // R8

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(req_in));  // R5

  AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_out) |-> $past(ack_in));  // R7

  AST_BLOCK_DRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && $past(block_mode) && $fell(drq)) |-> (dma_end || phase_err));  // R4

  AST_NORMAL_DRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_mode && !$past(block_mode) && $past(drq) && $past(dack)) |-> !drq);  // R3

  AST_MISMATCH_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_err) |-> !ack_out);  // R10

  AST_LAST_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_sent) |-> dma_end);  // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !phase_err) |-> $past(eop_irq_en));  // R11

endmodule

bind scsi_dma_engine sdma_checker i_sdma_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .block_mode (block_mode),
  .eop_irq_en (eop_irq_en),
  .drq        (drq),
  .dack       (dack),
  .req_in     (req_in),
  .ack_in     (ack_in),
  .req_out    (req_out),
  .ack_out    (ack_out),
  .dma_end    (dma_end),
  .last_sent  (last_sent),
  .phase_err  (phase_err),
  .irq        (irq)
);

// File: tb/test_scsi_dma_engine.sv
module test_scsi_dma_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic       block_mode, eop_irq_en;
  logic [2:0] phase_prog, bus_phase;
  logic       drq, dack, host_eop;
  logic [7:0] host_wdata, host_rdata;
  logic       req_in, ack_in, req_out, ack_out;
  logic [7:0] bus_din, bus_dout;
  logic       bus_doe, dma_end, last_sent, phase_err, irq;

  int total = 0;
  int bad   = 0;
  logic [7:0] bytes_q [8];

  always #10 clk = ~clk;

  scsi_dma_engine i_scsi_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .block_mode(block_mode), .eop_irq_en(eop_irq_en),
    .phase_prog(phase_prog), .bus_phase(bus_phase),
    .drq(drq), .dack(dack), .host_eop(host_eop),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_in(req_in), .ack_in(ack_in), .req_out(req_out), .ack_out(ack_out),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .dma_end(dma_end), .last_sent(last_sent), .phase_err(phase_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_irq(input bit en);
    return en ? 1 : 0;
  endfunction

  task automatic start_write(input logic [2:0] a);
    @(negedge clk);
    reg_wr   = 1'b1;
    reg_addr = a;
    @(negedge clk);
    reg_wr   = 1'b0;
  endtask

  task automatic host_take(input bit blk, input bit last, input bit is_send, input logic [7:0] b, input bit irq_en);
    chk(drq == 1'b1, blk ? "R4 drq when byte pending" : "R3 drq when byte pending", int'(drq), 1);
    dack       = 1'b1;
    host_wdata = b;
    host_eop   = last;
    @(negedge clk);
    dack     = 1'b0;
    host_eop = 1'b0;
    if (!is_send && last) begin
      chk(dma_end == 1'b1 && drq == 1'b0, "R8 receive end with drq low", int'({dma_end, drq}), 2);
      chk(last_sent == 1'b0, "R9 no last_sent on receive", int'(last_sent), 0);
      chk(int'(irq) == exp_irq(irq_en), "R11 irq gating", int'(irq), exp_irq(irq_en));
    end else if (blk) begin
      chk(drq == 1'b1, "R4 drq held after dack", int'(drq), 1);
    end else begin
      chk(drq == 1'b0, "R3 drq drops after dack", int'(drq), 0);
    end
  endtask

  task automatic run_xfer(input int dir, input bit blk, input int n, input bit irq_en);
    block_mode = blk;
    eop_irq_en = irq_en;
    phase_prog = 3'($urandom_range(0, 7));
    bus_phase  = phase_prog;
    for (int i = 0; i < n; i++) bytes_q[i] = 8'($urandom_range(0, 255));
    start_write(3'(5 + dir));
    chk(dma_end == 1'b0 && last_sent == 1'b0 && phase_err == 1'b0 && irq == 1'b0,
        "R12 flags cleared by start", int'({dma_end, last_sent, phase_err, irq}), 0);
    if (blk) chk(drq == 1'b1, "R4 drq after start", int'(drq), 1);
    for (int i = 0; i < n; i++) begin
      bit last = (i == n - 1);
      if (dir == 0) begin
        host_take(blk, last, 1'b1, bytes_q[i], irq_en);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        req_in = 1'b1;
        do @(negedge clk); while (ack_out !== 1'b1);
        chk(bus_doe == 1'b1 && bus_dout == bytes_q[i], "R5 send byte order", int'(bus_dout), int'(bytes_q[i]));
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          chk(ack_out == 1'b1, "R5 ack held while req high", int'(ack_out), 1);
        end
        if (blk) chk(drq == 1'b1, "R4 drq during handshake", int'(drq), 1);
        chk(dma_end == 1'b0, "R8 no end before handshake", int'(dma_end), 0);
        req_in = 1'b0;
        @(negedge clk);
        chk(ack_out == 1'b0, "R5 ack released after req fall", int'(ack_out), 0);
        if (last) begin
          chk(dma_end == 1'b1 && drq == 1'b0, "R8 send end with drq low", int'({dma_end, drq}), 2);
          chk(last_sent == 1'b1, "R9 last_sent after send", int'(last_sent), 1);
          chk(int'(irq) == exp_irq(irq_en), "R11 irq gating", int'(irq), exp_irq(irq_en));
        end else begin
          chk(dma_end == 1'b0, "R8 no early end", int'(dma_end), 0);
        end
      end else if (dir == 2) begin
        bus_din = ~bytes_q[i];
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(ack_out == 1'b0, "R6 no ack before req", int'(ack_out), 0);
        req_in = 1'b1;
        do @(negedge clk); while (ack_out !== 1'b1);
        if (blk) chk(drq == 1'b1, "R4 drq during handshake", int'(drq), 1);
        bus_din = bytes_q[i];
        req_in  = 1'b0;
        @(negedge clk);
        bus_din = bytes_q[i] ^ 8'h5A;
        chk(ack_out == 1'b0, "R6 ack released at req fall", int'(ack_out), 0);
        chk(host_rdata == bytes_q[i], "R6 capture on req fall", int'(host_rdata), int'(bytes_q[i]));
        host_take(blk, last, 1'b0, 8'h00, irq_en);
      end else begin
        bus_din = bytes_q[i] ^ 8'hC3;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(req_out == 1'b1, "R7 req asserted", int'(req_out), 1);
        bus_din = ~bytes_q[i];
        ack_in  = 1'b1;
        @(negedge clk);
        chk(req_out == 1'b0, "R7 req released on ack", int'(req_out), 0);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        bus_din = bytes_q[i];
        ack_in  = 1'b0;
        @(negedge clk);
        bus_din = bytes_q[i] ^ 8'h5A;
        chk(host_rdata == bytes_q[i], "R7 capture on ack fall", int'(host_rdata), int'(bytes_q[i]));
        host_take(blk, last, 1'b0, 8'h00, irq_en);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0;
    block_mode = 1'b0; eop_irq_en = 1'b0; phase_prog = 3'd0; bus_phase = 3'd0;
    dack = 1'b0; host_eop = 1'b0; host_wdata = 8'd0;
    req_in = 1'b0; ack_in = 1'b0; bus_din = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk({drq, ack_out, req_out, bus_doe, dma_end, last_sent, phase_err, irq} == 8'd0,
        "R1 reset state", int'({drq, ack_out, req_out, bus_doe, dma_end, last_sent, phase_err, irq}), 0);

    // non-start addresses in block mode: nothing may start
    block_mode = 1'b1;
    start_write(3'd4);
    start_write(3'd0);
    repeat (2) begin
      @(negedge clk);
      chk(drq == 1'b0 && req_out == 1'b0 && bus_doe == 1'b0, "R2 other address ignored",
          int'({drq, req_out, bus_doe}), 0);
    end

    // directed runs, each direction in both drq modes
    run_xfer(0, 1'b0, 3, 1'b1);
    run_xfer(0, 1'b1, 2, 1'b0);
    run_xfer(2, 1'b0, 3, 1'b0);
    run_xfer(2, 1'b1, 2, 1'b1);
    run_xfer(1, 1'b0, 3, 1'b1);
    run_xfer(1, 1'b1, 1, 1'b0);

    // strobe during a transfer is ignored (R2)
    block_mode = 1'b0;
    start_write(3'd6);
    chk(req_out == 1'b1, "R2 target receive started", int'(req_out), 1);
    start_write(3'd5);
    chk(req_out == 1'b1 && bus_doe == 1'b0 && drq == 1'b0, "R2 strobe while busy ignored",
        int'({req_out, bus_doe, drq}), 4);
    ack_in = 1'b1; bus_din = 8'h3C;
    @(negedge clk);
    ack_in = 1'b0;
    @(negedge clk);
    chk(host_rdata == 8'h3C, "R2 busy transfer kept its direction", int'(host_rdata), 8'h3C);
    host_take(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);

    // phase mismatch
    phase_prog = 3'b001;
    bus_phase  = 3'b111;
    eop_irq_en = 1'b0;
    start_write(3'd7);
    req_in = 1'b1;
    @(negedge clk);
    chk(ack_out == 1'b0, "R10 no ack on mismatch", int'(ack_out), 0);
    chk(phase_err == 1'b1 && irq == 1'b1, "R10 phase_err and irq", int'({phase_err, irq}), 3);
    chk(dma_end == 1'b0 && drq == 1'b0, "R10 no dma_end", int'({dma_end, drq}), 0);
    req_in = 1'b0;
    @(negedge clk);
    chk(ack_out == 1'b0, "R10 ack stays low", int'(ack_out), 0);

    // random runs
    for (int k = 0; k < 10; k++) begin
      run_xfer($urandom_range(0, 2), 1'($urandom_range(0, 1)), $urandom_range(1, 6),
               1'($urandom_range(0, 1)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule